// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

A parameterised `WIDTH`-bit integer adder/subtractor for an execution pipeline. One adder serves every operation. A subtract inverts the second operand and injects a carry of one, and the result wraps modulo 2^WIDTH. Each operation produces a combinational result and a strobe that says whether the result should be written back. When the flag-write enable is set, the operation also records a zero, negative, overflow and carry flag at the next rising clock edge.

The stored flags feed a condition decoder. A 4-bit code selects a test of a single flag or a signed or unsigned relation. All relations are formed from the same four flags, so no separate signed or unsigned instruction is needed. Compare runs the subtract path and updates only the flags.

The carry-consuming operations take the stored carry flag as their carry-in. This lets software build 2·WIDTH-bit sums and differences from two chained operations.

Top module: `addsub_flag_alu`

## Requirements
- R1: Operation code 0 (add) returns (a + b) mod 2^WIDTH. Code 1 (add with carry) returns (a + b + C) mod 2^WIDTH, where C is the stored carry flag.
- R2: Code 2 (subtract) returns (a + ~b + 1) mod 2^WIDTH. Code 3 (subtract with borrow) returns (a + ~b + C) mod 2^WIDTH, so C=1 means no pending borrow.
- R3: On a flag write, Z is set when the result is all zeros, and N takes the top result bit.
- R4: On a flag write, C takes the carry out of the top adder bit. For subtract-type operations, C=1 therefore means no borrow occurred.
- R5: On a flag write, V is set when both adder inputs (b after inversion for subtract types) share a sign and the result's top bit differs from it.
- R6: Flags change only at a rising clock edge with `flag_we_i` high; otherwise they hold.
- R7: Code 4 (compare) updates the flags exactly as subtract would, with `res_we_o` low. Codes 0 to 3 drive `res_we_o` high.
- R8: Codes 5 to 7 are reserved. They drive `res_we_o` low and leave the flags unchanged even with `flag_we_i` high.
- R9: `cond_o` uses these single-flag codes: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V.
- R10: `cond_o` uses these unsigned codes: 8 below (!C), 9 below-or-equal (!C|Z), 10 above (C&!Z), 11 above-or-equal (C). After a compare they match a<b, a<=b, a>b, a>=b unsigned.
- R11: `cond_o` uses these signed codes: 12 less (N^V), 13 less-or-equal ((N^V)|Z), 14 greater (!(N^V)&!Z), 15 greater-or-equal (!(N^V)). After a compare they match the signed relations.
- R12: While `rst_ni` is low, and after its release until the first flag write, all four flags are zero.
- R13: An add followed by an add-with-carry, or a subtract followed by a subtract-with-borrow, both with flag writes, yields the 2·WIDTH-bit sum or difference (mod 2^(2·WIDTH)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| flag_we_i | input | 1 | Record flags at next rising edge |
| cond_i | input | 4 | Condition code to evaluate |
| res_o | output | WIDTH | Truncated result |
| res_we_o | output | 1 | Result write strobe |
| flag_z_o | output | 1 | Stored zero flag |
| flag_n_o | output | 1 | Stored negative flag |
| flag_v_o | output | 1 | Stored overflow flag |
| flag_c_o | output | 1 | Stored carry flag |
| cond_o | output | 1 | Selected condition is true |

## Verification
The hardest case to reach from the ports is an operation that consumes the stored carry while that carry holds a specific value. The flag register is only reachable through earlier operations. The stimulus therefore precedes every sweep point with a flag-writing add that forces C to 0 or 1: 0+0 clears it and max+1 sets it. Each carry-consuming code then runs over every operand pair of a 4-bit instance with both carry states. Compare results are checked against plain signed and unsigned relations of the operands. Chained double-width sums and differences are checked against arithmetic on 8-bit values.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_CMP = 3'd4
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_EQ  = 4'd0,
    CC_NE  = 4'd1,
    CC_CS  = 4'd2,
    CC_CC  = 4'd3,
    CC_MI  = 4'd4,
    CC_PL  = 4'd5,
    CC_VS  = 4'd6,
    CC_VC  = 4'd7,
    CC_LTU = 4'd8,
    CC_LEU = 4'd9,
    CC_GTU = 4'd10,
    CC_GEU = 4'd11,
    CC_LTS = 4'd12,
    CC_LES = 4'd13,
    CC_GTS = 4'd14,
    CC_GES = 4'd15
  } cond_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_stored_i,
  output logic [WIDTH-1:0] b_eff_o,
  output logic             cin_o
);

  logic inv_b;

  always_comb begin
    inv_b = 1'b0;
    cin_o = 1'b0;
    unique case (op_i)
      OP_ADD:  begin inv_b = 1'b0; cin_o = 1'b0;       end
      OP_ADC:  begin inv_b = 1'b0; cin_o = c_stored_i; end
      OP_SUB,
      OP_CMP:  begin inv_b = 1'b1; cin_o = 1'b1;       end
      OP_SBC:  begin inv_b = 1'b1; cin_o = c_stored_i; end
      default: begin inv_b = 1'b0; cin_o = 1'b0;       end
    endcase
  end

  assign b_eff_o = inv_b ? ~b_i : b_i;

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int SumW = WIDTH + 1;

  if (RIPPLE) begin : g_ripple
    always_comb begin
      logic cy;
      cy = cin_i;
      for (int i = 0; i < WIDTH; i++) begin
        sum_o[i] = a_i[i] ^ b_i[i] ^ cy;
        cy       = (a_i[i] & b_i[i]) | (cy & (a_i[i] ^ b_i[i]));
      end
      cout_o = cy;
    end
  end else begin : g_behav
    logic [SumW-1:0] full;
    assign full   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    assign sum_o  = full[WIDTH-1:0];
    assign cout_o = full[WIDTH];
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             cout_i,
  input  logic             a_msb_i,
  input  logic             b_msb_i,
  output flags_t           flags_o
);

  flags_t nxt;
  logic   res_msb;

  assign res_msb = sum_i[WIDTH-1];

  always_comb begin
    nxt.z = (sum_i == '0);
    nxt.n = res_msb;
    nxt.c = cout_i;
    // like-signed inputs with a result of the other sign
    nxt.v = (a_msb_i == b_msb_i) && (res_msb != a_msb_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_o <= '0;
    else if (we_i) flags_o <= nxt;
  end

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_pkg::*;
(
  input  flags_t     flags_i,
  input  logic [3:0] cond_i,
  output logic       cond_o
);

  logic lt_s, lt_u;

  assign lt_s = flags_i.n ^ flags_i.v;
  assign lt_u = ~flags_i.c;

  always_comb begin
    unique case (cond_e'(cond_i))
      CC_EQ:   cond_o = flags_i.z;
      CC_NE:   cond_o = ~flags_i.z;
      CC_CS:   cond_o = flags_i.c;
      CC_CC:   cond_o = ~flags_i.c;
      CC_MI:   cond_o = flags_i.n;
      CC_PL:   cond_o = ~flags_i.n;
      CC_VS:   cond_o = flags_i.v;
      CC_VC:   cond_o = ~flags_i.v;
      CC_LTU:  cond_o = lt_u;
      CC_LEU:  cond_o = lt_u | flags_i.z;
      CC_GTU:  cond_o = ~(lt_u | flags_i.z);
      CC_GEU:  cond_o = ~lt_u;
      CC_LTS:  cond_o = lt_s;
      CC_LES:  cond_o = lt_s | flags_i.z;
      CC_GTS:  cond_o = ~(lt_s | flags_i.z);
      CC_GES:  cond_o = ~lt_s;
      default: cond_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/addsub_flag_alu.sv
module addsub_flag_alu
  import alu_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             flag_we_i,
  input  logic [3:0]       cond_i,
  output logic [WIDTH-1:0] res_o,
  output logic             res_we_o,
  output logic             flag_z_o,
  output logic             flag_n_o,
  output logic             flag_v_o,
  output logic             flag_c_o,
  output logic             cond_o
);

  localparam int MsbIdx = WIDTH - 1;

  flags_t           flags;
  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic             cout;
  logic             op_known;

  assign op_known = (op_i <= OP_CMP);
  assign res_we_o = op_known && (op_i != OP_CMP);

  alu_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .op_i       (op_i),
    .b_i        (b_i),
    .c_stored_i (flags.c),
    .b_eff_o    (b_eff),
    .cin_o      (cin)
  );

  alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (cin),
    .sum_o  (res_o),
    .cout_o (cout)
  );

  alu_flag_reg #(.WIDTH(WIDTH)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (flag_we_i && op_known),
    .sum_i   (res_o),
    .cout_i  (cout),
    .a_msb_i (a_i[MsbIdx]),
    .b_msb_i (b_eff[MsbIdx]),
    .flags_o (flags)
  );

  alu_cond_eval u_cond (
    .flags_i (flags),
    .cond_i  (cond_i),
    .cond_o  (cond_o)
  );

  assign flag_z_o = flags.z;
  assign flag_n_o = flags.n;
  assign flag_v_o = flags.v;
  assign flag_c_o = flags.c;

endmodule

// File: rtl/addsub_flag_alu_chk.sv
module addsub_flag_alu_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       op_i,
  input logic             flag_we_i,
  input logic [3:0]       cond_i,
  input logic [WIDTH-1:0] res_o,
  input logic             res_we_o,
  input logic             flag_z_o,
  input logic             flag_n_o,
  input logic             flag_v_o,
  input logic             flag_c_o,
  input logic             cond_o
);

  AST_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP) |-> !res_we_o); // R7

  AST_RESERVED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > OP_CMP) |-> !res_we_o); // R8

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable({flag_z_o, flag_n_o, flag_v_o, flag_c_o})); // R6

  AST_RESERVED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > OP_CMP) |=> $stable({flag_z_o, flag_n_o, flag_v_o, flag_c_o})); // R8

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i <= OP_CMP) |=> (flag_z_o == ($past(res_o) == '0))); // R3

  AST_NEG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i <= OP_CMP) |=> (flag_n_o == $past(res_o[WIDTH-1]))); // R3

  AST_EQ_FOLLOWS_Z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == CC_EQ) |-> (cond_o == flag_z_o)); // R9

  AST_GEU_FOLLOWS_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == CC_GEU) |-> (cond_o == flag_c_o)); // R10

  AST_LTS_SIGN_XOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == CC_LTS) |-> (cond_o == (flag_n_o ^ flag_v_o))); // R11

endmodule

bind addsub_flag_alu addsub_flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .flag_we_i (flag_we_i),
  .cond_i    (cond_i),
  .res_o     (res_o),
  .res_we_o  (res_we_o),
  .flag_z_o  (flag_z_o),
  .flag_n_o  (flag_n_o),
  .flag_v_o  (flag_v_o),
  .flag_c_o  (flag_c_o),
  .cond_o    (cond_o)
);

// File: tb/addsub_flag_alu_tb.sv
`timescale 1ns/1ps
module addsub_flag_alu_tb;

  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;
  localparam int HALF = 1 << (W - 1);

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   op_i = '0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         flag_we_i = 1'b0;
  logic [3:0]   cond_i = '0;
  logic [W-1:0] res_o;
  logic         res_we_o;
  logic         flag_z_o, flag_n_o, flag_v_o, flag_c_o, cond_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // model flags
  bit mz, mn, mv, mc;

  always #10 clk_i = ~clk_i;

  addsub_flag_alu #(.WIDTH(W), .RIPPLE(1'b1)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flag_we_i(flag_we_i), .cond_i(cond_i), .res_o(res_o), .res_we_o(res_we_o),
    .flag_z_o(flag_z_o), .flag_n_o(flag_n_o), .flag_v_o(flag_v_o),
    .flag_c_o(flag_c_o), .cond_o(cond_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sgn(input int x);
    return (x >= HALF) ? x - (1 << W) : x;
  endfunction

  function automatic int flag_word(input bit z, input bit n, input bit v, input bit c);
    return {28'd0, z, n, v, c};
  endfunction

  // R9, R10, R11 formulas over model flags
  function automatic bit exp_cond(input int code);
    bit lts, ltu;
    lts = mn ^ mv;
    ltu = !mc;
    case (code)
      0: return mz;       1: return !mz;
      2: return mc;       3: return !mc;
      4: return mn;       5: return !mn;
      6: return mv;       7: return !mv;
      8: return ltu;      9: return ltu | mz;
      10: return !(ltu | mz); 11: return !ltu;
      12: return lts;     13: return lts | mz;
      14: return !(lts | mz); default: return !lts;
    endcase
  endfunction

  // expected result and next flags from arithmetic (R1..R5)
  task automatic model(input int op, input int a, input int b,
                       output int res, output bit z, output bit n, output bit v, output bit c);
    int cin, beff, sum, sval;
    bit sub;
    sub  = (op == 2 || op == 3 || op == 4);
    cin  = (op == 0) ? 0 : (op == 1 || op == 3) ? int'(mc) : 1;
    beff = sub ? (~b & MASK) : b;
    sum  = a + beff + cin;
    res  = sum & MASK;
    c    = (sum >> W) != 0;
    z    = (res == 0);
    n    = (res >= HALF);
    sval = sub ? (sgn(a) - sgn(b) - (1 - cin)) : (sgn(a) + sgn(b) + cin);
    v    = (sval < -HALF) || (sval >= HALF);
  endtask

  task automatic drive(input int op, input int a, input int b, input bit we);
    @(negedge clk_i);
    op_i = op[2:0]; a_i = a[W-1:0]; b_i = b[W-1:0]; flag_we_i = we;
    #1;
  endtask

  task automatic edge_tick();
    @(posedge clk_i);
    #1;
    flag_we_i = 1'b0;
  endtask

  task automatic do_op(input int op, input int a, input int b, input bit we);
    int r; bit z, n, v, c;
    drive(op, a, b, we);
    model(op, a, b, r, z, n, v, c);
    edge_tick();
    if (we && op <= 4) begin mz = z; mn = n; mv = v; mc = c; end
  endtask

  task automatic chk_flags(input string req);
    chk(req, flag_word(flag_z_o, flag_n_o, flag_v_o, flag_c_o), flag_word(mz, mn, mv, mc));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      chk("watchdog", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int r; bit z, n, v, c;
    mz = 0; mn = 0; mv = 0; mc = 0;
    #5;
    chk_flags("R12 in reset");
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk_flags("R12 after release");
    cond_i = 4'd1; #1; chk("R12 NE after reset", cond_o, 1);

    // sweep every op, stored carry, operand pair
    for (int op = 0; op <= 4; op++) begin
      for (int cs = 0; cs <= 1; cs++) begin
        for (int a = 0; a <= MASK; a++) begin
          for (int b = 0; b <= MASK; b++) begin
            do_op(0, cs ? MASK : 0, cs ? 1 : 0, 1'b1);
            drive(op, a, b, 1'b1);
            model(op, a, b, r, z, n, v, c);
            if (op == 0 || op == 1) chk("R1 result", res_o, r);
            if (op == 2 || op == 3) chk("R2 result", res_o, r);
            chk("R7 write strobe", res_we_o, (op == 4) ? 0 : 1);
            edge_tick();
            mz = z; mn = n; mv = v; mc = c;
            chk("R3 Z", flag_z_o, mz);
            chk("R3 N", flag_n_o, mn);
            chk("R4 C", flag_c_o, mc);
            chk("R5 V", flag_v_o, mv);
            for (int cd = 0; cd < 16; cd++) begin
              cond_i = cd[3:0];
              #0.5;
              if (cd < 8)       chk("R9 cond", cond_o, exp_cond(cd));
              else if (cd < 12) chk("R10 cond", cond_o, exp_cond(cd));
              else              chk("R11 cond", cond_o, exp_cond(cd));
              if (op == 4) begin
                case (cd)
                  0:  chk("R9 cmp eq", cond_o, a == b);
                  8:  chk("R10 cmp ltu", cond_o, a < b);
                  9:  chk("R10 cmp leu", cond_o, a <= b);
                  10: chk("R10 cmp gtu", cond_o, a > b);
                  11: chk("R10 cmp geu", cond_o, a >= b);
                  12: chk("R11 cmp lts", cond_o, sgn(a) < sgn(b));
                  13: chk("R11 cmp les", cond_o, sgn(a) <= sgn(b));
                  14: chk("R11 cmp gts", cond_o, sgn(a) > sgn(b));
                  15: chk("R11 cmp ges", cond_o, sgn(a) >= sgn(b));
                  default: ;
                endcase
              end
            end
          end
        end
      end
    end

    // R6: no flag write enable, flags hold
    do_op(0, MASK, 1, 1'b1);
    chk_flags("R6 setup");
    for (int op = 0; op <= 4; op++) begin
      drive(op, 3, 5, 1'b0);
      edge_tick();
      chk_flags("R6 hold");
    end

    // R8: reserved codes
    for (int op = 5; op <= 7; op++) begin
      drive(op, 7, 9, 1'b1);
      chk("R8 write strobe", res_we_o, 0);
      edge_tick();
      chk_flags("R8 flags held");
    end

    // R13: chained double-width add and subtract
    for (int x = 0; x < 256; x += 13) begin
      for (int y = 0; y < 256; y += 11) begin
        int lo, hi;
        drive(0, x & MASK, y & MASK, 1'b1); lo = res_o; edge_tick();
        drive(1, x >> W, y >> W, 1'b1);     hi = res_o; edge_tick();
        chk("R13 chained add", (hi << W) | lo, (x + y) & 255);
        drive(2, x & MASK, y & MASK, 1'b1); lo = res_o; edge_tick();
        drive(3, x >> W, y >> W, 1'b1);     hi = res_o; edge_tick();
        chk("R13 chained sub", (hi << W) | lo, (x - y) & 255);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule